// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps the single address reservation of one hart so that reserved loads and conditional stores, in word and quadword sizes, can build atomic read-modify-write sequences. A reserved load records the 128-byte granule it touched. A later conditional store succeeds only while that reservation is still held and still covers the store's granule. The core is told pass or fail, which it writes into its condition field. Only a passing conditional store is forwarded to memory as a write.

The reservation is lost in several ways. A store from another agent that hits the granule ends it. So does any conditional store, an explicit clear request, or a context save/restore event, unless record-replay mode is on. A parameter chooses whether the hart's own plain store into the granule also ends it. Reserved accesses that are not naturally aligned do not execute. Instead they raise an alignment exception request with vector 0x600.

Top module: `lsc_resv_monitor`

## Requirements
- R1: A conditional store matches the reservation on address bits [ADDR_W-1:7] only. Any aligned store inside the reserved 128-byte granule passes, and one in a neighbouring granule fails.
- R2: A conditional store made while no reservation is held gives resp_valid=1 and resp_pass=0, and it does not assert mem_we.
- R3: A passing conditional store asserts mem_we and resp_pass and ends the reservation, so a repeated conditional store to the same address fails. Any conditional store, passing or failing, ends the reservation.
- R4: A reserved load is misaligned when the word case (req_quad=0) has req_addr[1:0]≠0, or the quadword case (req_quad=1) has req_addr[3:0]≠0. Such a load gives rd_we=00 and exc_req=1 with exc_vector=0x600, and it leaves any held reservation unchanged.
- R5: A misaligned conditional store gives exc_req=1 with vector 0x600, resp_pass=0 and mem_we=0.
- R6: A quadword reserved load gives rd_we=11, with rd_even=mem_rdata[127:64] and rd_odd=mem_rdata[63:0]. A word reserved load gives rd_we=01 and rd_even={32'b0, mem_rdata[31:0]}. A passing quadword store writes mem_wdata={st_even, st_odd} with mem_wide=1. A passing word store writes mem_wdata={96'b0, st_even[31:0]} with mem_wide=0.
- R7: A ctx_loss pulse with replay_mode=0 clears the reservation. With replay_mode=1 the reservation is kept.
- R8: A plain store (req_op=2) always writes memory. With OWN_STORE_KILLS=1 (the default), a plain store into the reserved granule clears the reservation, while one to another granule does not.
- R9: A snoop_valid pulse whose snoop_addr falls in the reserved granule clears the reservation. A snoop to another granule does not.
- R10: An aligned reserved load replaces any earlier reservation with its own granule.
- R11: After reset no reservation is held and all strobes are low. The request codes are reserve=0, conditional store=1, plain store=2 and clear=3, and a clear request removes the reservation. Each response and strobe appears one cycle after its request and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 reserve-load, 1 conditional store, 2 plain store, 3 clear |
| req_addr | input | ADDR_W | Byte address of the request |
| req_quad | input | 1 | 1 quadword (16 bytes), 0 word (4 bytes) |
| st_even | input | DATA_W | Store data, even register of the pair |
| st_odd | input | DATA_W | Store data, odd register of the pair |
| mem_rdata | input | 2*DATA_W | Memory read data for a reserve-load, same cycle as the request |
| snoop_valid | input | 1 | Store by another agent observed |
| snoop_addr | input | ADDR_W | Address of the snooped store |
| ctx_loss | input | 1 | Context save/restore event |
| replay_mode | input | 1 | Record-replay mode keeps reservations across ctx_loss |
| resp_valid | output | 1 | Conditional-store result strobe |
| resp_pass | output | 1 | Conditional store succeeded |
| mem_we | output | 1 | Write enable toward memory |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | 2*DATA_W | Write data |
| mem_wide | output | 1 | Write is a quadword |
| rd_we | output | 2 | Register write enables {odd, even} |
| rd_even | output | DATA_W | Load result, even register |
| rd_odd | output | DATA_W | Load result, odd register |
| exc_req | output | 1 | Alignment exception request |
| exc_vector | output | 12 | Exception vector (0x600) |

## Verification
Every result of this block is due on the first rising edge after its request: the pass/fail strobe, the memory write, the register write enables and the exception request. The reservation effect of a snoop, a ctx_loss or a plain store therefore holds from the next request onward. The bench drives each request on a falling edge, waits exactly one falling edge, and samples there. It checks a strobe's single-cycle width by sampling one more falling edge later. Granule matching and alignment are swept over every word offset and every low-address pattern, and the expected outcome of each case is computed from the offset.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    OP_RSV = 2'd0,
    OP_CS  = 2'd1,
    OP_ST  = 2'd2,
    OP_CLR = 2'd3
  } lsc_op_e;
endpackage

// File: rtl/lsc_align_chk.sv
module lsc_align_chk #(
  parameter int LSB_W    = 4,
  parameter int WORD_LSB = 2
) (
  input  logic [LSB_W-1:0] low_addr,
  input  logic             quad,
  output logic             aligned
);
  always_comb begin
    if (quad) aligned = (low_addr == '0);
    else      aligned = (low_addr[WORD_LSB-1:0] == '0);
  end
endmodule

// File: rtl/lsc_resv_reg.sv
module lsc_resv_reg
  import lsc_pkg::*;
#(
  parameter int TAG_W           = 25,
  parameter bit OWN_STORE_KILLS = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  lsc_op_e          req_op,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             aligned,
  input  logic             snoop_valid,
  input  logic [TAG_W-1:0] snoop_tag,
  input  logic             ctx_loss,
  input  logic             replay_mode,
  output logic             cs_pass
);
  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             tag_en;
  logic             snoop_kill, ctx_kill, live, tag_hit;
  logic             is_rsv, is_cs, is_st, is_clr;

  always_comb begin
    is_rsv     = req_valid && (req_op == OP_RSV);
    is_cs      = req_valid && (req_op == OP_CS);
    is_st      = req_valid && (req_op == OP_ST);
    is_clr     = req_valid && (req_op == OP_CLR);
    tag_hit    = (req_tag == tag_q);
    snoop_kill = snoop_valid && valid_q && (snoop_tag == tag_q);
    ctx_kill   = ctx_loss && !replay_mode;
    live       = valid_q && !snoop_kill && !ctx_kill;
    cs_pass    = is_cs && aligned && live && tag_hit;
  end

  always_comb begin
    valid_d = live;
    tag_d   = tag_q;
    tag_en  = 1'b0;
    if (is_rsv && aligned) begin
      valid_d = 1'b1;
      tag_d   = req_tag;
      tag_en  = 1'b1;
    end else if (is_cs || is_clr) begin
      valid_d = 1'b0;
    end else if (is_st && OWN_STORE_KILLS && tag_hit) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (tag_en) tag_q <= tag_d;
  end
endmodule

// File: rtl/lsc_resp_stage.sv
module lsc_resp_stage
  import lsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  lsc_op_e               req_op,
  input  logic                  req_quad,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  aligned,
  input  logic                  cs_pass,
  input  logic [DATA_W-1:0]     st_even,
  input  logic [DATA_W-1:0]     st_odd,
  input  logic [2*DATA_W-1:0]   mem_rdata,
  output logic                  resp_valid,
  output logic                  resp_pass,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [2*DATA_W-1:0]   mem_wdata,
  output logic                  mem_wide,
  output logic [1:0]            rd_we,
  output logic [DATA_W-1:0]     rd_even,
  output logic [DATA_W-1:0]     rd_odd,
  output logic                  exc_req
);
  localparam int WIDE_W = 2 * DATA_W;

  logic                resp_valid_d, resp_pass_d, mem_we_d, exc_d;
  logic [1:0]          rd_we_d;
  logic [DATA_W-1:0]   rd_even_d, rd_odd_d;
  logic [WIDE_W-1:0]   wdata_d;
  logic                is_rsv, is_cs, is_st;

  always_comb begin
    is_rsv       = req_valid && (req_op == OP_RSV);
    is_cs        = req_valid && (req_op == OP_CS);
    is_st        = req_valid && (req_op == OP_ST);
    resp_valid_d = is_cs;
    resp_pass_d  = cs_pass;
    mem_we_d     = cs_pass || is_st;
    exc_d        = (is_rsv || is_cs) && !aligned;
    rd_we_d      = 2'b00;
    if (is_rsv && aligned) rd_we_d = req_quad ? 2'b11 : 2'b01;
    if (req_quad) begin
      rd_even_d = mem_rdata[WIDE_W-1:DATA_W];
      wdata_d   = {st_even, st_odd};
    end else begin
      rd_even_d = {{(DATA_W-WORD_W){1'b0}}, mem_rdata[WORD_W-1:0]};
      wdata_d   = {{(WIDE_W-WORD_W){1'b0}}, st_even[WORD_W-1:0]};
    end
    rd_odd_d = mem_rdata[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_pass  <= 1'b0;
      mem_we     <= 1'b0;
      exc_req    <= 1'b0;
      rd_we      <= 2'b00;
    end else begin
      resp_valid <= resp_valid_d;
      resp_pass  <= resp_pass_d;
      mem_we     <= mem_we_d;
      exc_req    <= exc_d;
      rd_we      <= rd_we_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we_d) begin
      mem_addr  <= req_addr;
      mem_wdata <= wdata_d;
      mem_wide  <= req_quad;
    end
    if (rd_we_d[0]) rd_even <= rd_even_d;
    if (rd_we_d[1]) rd_odd  <= rd_odd_d;
  end
endmodule

// File: rtl/lsc_resv_monitor.sv
module lsc_resv_monitor
  import lsc_pkg::*;
#(
  parameter int          ADDR_W          = 32,
  parameter int          GRAN_LSB        = 7,
  parameter int          DATA_W          = 64,
  parameter bit          OWN_STORE_KILLS = 1'b1,
  parameter logic [11:0] EXC_VEC         = 12'h600
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [1:0]            req_op,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_quad,
  input  logic [DATA_W-1:0]     st_even,
  input  logic [DATA_W-1:0]     st_odd,
  input  logic [2*DATA_W-1:0]   mem_rdata,
  input  logic                  snoop_valid,
  input  logic [ADDR_W-1:0]     snoop_addr,
  input  logic                  ctx_loss,
  input  logic                  replay_mode,
  output logic                  resp_valid,
  output logic                  resp_pass,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [2*DATA_W-1:0]   mem_wdata,
  output logic                  mem_wide,
  output logic [1:0]            rd_we,
  output logic [DATA_W-1:0]     rd_even,
  output logic [DATA_W-1:0]     rd_odd,
  output logic                  exc_req,
  output logic [11:0]           exc_vector
);
  localparam int TAG_W    = ADDR_W - GRAN_LSB;
  localparam int QUAD_LSB = $clog2(2 * DATA_W / 8);
  localparam int WORD_LSB = 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       aligned, cs_pass;
  lsc_op_e    op;
  logic       unused_snoop_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n        = rst_sync_q[1];
  assign op               = lsc_op_e'(req_op);
  assign exc_vector       = EXC_VEC;
  assign unused_snoop_low = ^snoop_addr[GRAN_LSB-1:0];

  lsc_align_chk #(.LSB_W(QUAD_LSB), .WORD_LSB(WORD_LSB)) i_align (
    .low_addr (req_addr[QUAD_LSB-1:0]),
    .quad     (req_quad),
    .aligned  (aligned)
  );

  lsc_resv_reg #(.TAG_W(TAG_W), .OWN_STORE_KILLS(OWN_STORE_KILLS)) i_resv (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid),
    .req_op      (op),
    .req_tag     (req_addr[ADDR_W-1:GRAN_LSB]),
    .aligned     (aligned),
    .snoop_valid (snoop_valid),
    .snoop_tag   (snoop_addr[ADDR_W-1:GRAN_LSB]),
    .ctx_loss    (ctx_loss),
    .replay_mode (replay_mode),
    .cs_pass     (cs_pass)
  );

  lsc_resp_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(32)) i_resp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_op     (op),
    .req_quad   (req_quad),
    .req_addr   (req_addr),
    .aligned    (aligned),
    .cs_pass    (cs_pass),
    .st_even    (st_even),
    .st_odd     (st_odd),
    .mem_rdata  (mem_rdata),
    .resp_valid (resp_valid),
    .resp_pass  (resp_pass),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_wide   (mem_wide),
    .rd_we      (rd_we),
    .rd_even    (rd_even),
    .rd_odd     (rd_odd),
    .exc_req    (exc_req)
  );
endmodule

// File: rtl/lsc_resv_monitor_chk.sv
module lsc_resv_monitor_chk #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              snoop_valid,
  input logic [ADDR_W-1:0] snoop_addr,
  input logic              ctx_loss,
  input logic              replay_mode,
  input logic              resp_valid,
  input logic              resp_pass,
  input logic              mem_we,
  input logic [1:0]        rd_we,
  input logic              exc_req
);
  // R2: a failing conditional store never writes memory
  a_r2_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_pass) |-> !mem_we);

  // R3: two back-to-back conditional stores, the second always fails
  a_r3_second_cs_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd1) ##1 (req_valid && req_op == 2'd1) |=> !resp_pass);

  // R4 / R5: an alignment exception suppresses writes and success
  a_r4_exc_blocks_effects: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (rd_we == 2'b00 && !mem_we && !resp_pass));

  // R7: context loss without replay kills the reservation
  a_r7_ctx_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_loss && !replay_mode && !(req_valid && req_op == 2'd0))
      ##1 (req_valid && req_op == 2'd1) |=> !resp_pass);

  // R9: a snoop hit on the granule makes the next conditional store fail
  a_r9_snoop_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd1 &&
     $past(snoop_valid && !(req_valid && req_op == 2'd0)) &&
     req_addr[ADDR_W-1:GRAN_LSB] == $past(snoop_addr[ADDR_W-1:GRAN_LSB]))
      |=> !resp_pass);

  // R11: a result strobe only follows a conditional-store request
  a_r11_resp_follows_cs: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && req_op == 2'd1));
endmodule

bind lsc_resv_monitor lsc_resv_monitor_chk #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_addr    (req_addr),
  .snoop_valid (snoop_valid),
  .snoop_addr  (snoop_addr),
  .ctx_loss    (ctx_loss),
  .replay_mode (replay_mode),
  .resp_valid  (resp_valid),
  .resp_pass   (resp_pass),
  .mem_we      (mem_we),
  .rd_we       (rd_we),
  .exc_req     (exc_req)
);

// File: tb/test_lsc_resv_monitor.sv
`timescale 1ns/1ps
module test_lsc_resv_monitor;
  import lsc_pkg::*;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic [1:0]   req_op;
  logic [31:0]  req_addr;
  logic         req_quad;
  logic [63:0]  st_even, st_odd;
  logic [127:0] mem_rdata;
  logic         snoop_valid;
  logic [31:0]  snoop_addr;
  logic         ctx_loss, replay_mode;
  logic         resp_valid, resp_pass, mem_we, mem_wide, exc_req;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [1:0]   rd_we;
  logic [63:0]  rd_even, rd_odd;
  logic [11:0]  exc_vector;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lsc_resv_monitor i_lsc_resv_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_quad(req_quad), .st_even(st_even), .st_odd(st_odd),
    .mem_rdata(mem_rdata), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .ctx_loss(ctx_loss), .replay_mode(replay_mode), .resp_valid(resp_valid),
    .resp_pass(resp_pass), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wide(mem_wide), .rd_we(rd_we),
    .rd_even(rd_even), .rd_odd(rd_odd), .exc_req(exc_req), .exc_vector(exc_vector)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge
  task automatic do_req(input lsc_op_e op, input logic [31:0] a, input logic q);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_quad = q;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cs_expect(input logic [31:0] a, input logic q, input bit pass,
                           input string tag);
    do_req(OP_CS, a, q);
    chk(resp_valid == 1'b1, tag, 128'(resp_valid), 128'd1);
    chk(resp_pass == pass, tag, 128'(resp_pass), 128'(pass));
    chk(mem_we == pass, tag, 128'(mem_we), 128'(pass));
  endtask

  task automatic pulse(input bit snp, input logic [31:0] a, input bit ctx);
    @(negedge clk);
    snoop_valid = snp; snoop_addr = a; ctx_loss = ctx;
    @(negedge clk);
    snoop_valid = 1'b0; ctx_loss = 1'b0;
  endtask

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_quad = 1'b0;
    st_even = 64'h1111_2222_DEAD_BEEF; st_odd = 64'h3333_4444_5555_6666;
    mem_rdata = 128'hA0A1A2A3A4A5A6A7_B0B1B2B3C0C1C2C3;
    snoop_valid = 1'b0; snoop_addr = '0; ctx_loss = 1'b0; replay_mode = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk(resp_valid == 0 && mem_we == 0 && exc_req == 0 && rd_we == 0,
        "R11 reset strobes", 128'({resp_valid, mem_we, exc_req, rd_we}), 128'd0);
    chk(exc_vector == 12'h600, "R4 vector", 128'(exc_vector), 128'h600);

    // R2 no reservation after reset
    cs_expect(32'h1000, 1'b0, 1'b0, "R2 cs without reservation");

    // R3 / R6 word path
    do_req(OP_RSV, 32'h1000, 1'b0);
    chk(rd_we == 2'b01, "R6 word rd_we", 128'(rd_we), 128'd1);
    chk(rd_even == {32'd0, mem_rdata[31:0]}, "R6 word load", 128'(rd_even),
        128'({32'd0, mem_rdata[31:0]}));
    cs_expect(32'h1000, 1'b0, 1'b1, "R3 cs pass");
    chk(mem_wdata == {96'd0, st_even[31:0]} && mem_wide == 0 && mem_addr == 32'h1000,
        "R6 word write", mem_wdata, {96'd0, st_even[31:0]});
    @(negedge clk);
    chk(resp_valid == 0 && mem_we == 0, "R11 single-cycle strobe",
        128'({resp_valid, mem_we}), 128'd0);
    cs_expect(32'h1000, 1'b0, 1'b0, "R3 repeated cs fails");

    // R1 sweep every word offset inside the granule
    for (int off = 0; off < 128; off += 4) begin
      do_req(OP_RSV, 32'h2000, 1'b0);
      cs_expect(32'h2000 + off, 1'b0, 1'b1, "R1 offset inside granule");
    end
    do_req(OP_RSV, 32'h2000, 1'b0);
    cs_expect(32'h2080, 1'b0, 1'b0, "R1 next granule");
    do_req(OP_RSV, 32'h2000, 1'b0);
    cs_expect(32'h1F80, 1'b0, 1'b0, "R1 previous granule");

    // R4 / R10 alignment sweep of reserve-loads, both sizes
    for (int q = 0; q < 2; q++) begin
      for (int off = 0; off < 16; off++) begin
        bit mis;
        mis = (q == 1) ? (off != 0) : ((off % 4) != 0);
        do_req(OP_RSV, 32'h3000, 1'b0);
        do_req(OP_RSV, 32'h4000 + off, q[0]);
        chk(exc_req == mis, "R4 exc on misaligned reserve", 128'(exc_req), 128'(mis));
        chk(rd_we == (mis ? 2'b00 : (q == 1 ? 2'b11 : 2'b01)), "R4 rd_we",
            128'(rd_we), 128'(mis ? 2'b00 : (q == 1 ? 2'b11 : 2'b01)));
        // misaligned keeps old reservation, aligned replaces it (R10)
        cs_expect(32'h3000, 1'b0, mis, "R4 R10 old reservation");
      end
    end

    // R5 misaligned conditional stores
    for (int off = 1; off < 16; off++) begin
      do_req(OP_RSV, 32'h5000, 1'b1);
      do_req(OP_CS, 32'h5000 + off, 1'b1);
      chk(exc_req == 1 && resp_valid == 1 && resp_pass == 0 && mem_we == 0,
          "R5 misaligned cs", 128'({exc_req, resp_valid, resp_pass, mem_we}), 128'b1100);
    end

    // R6 quadword pair
    do_req(OP_RSV, 32'h5010, 1'b1);
    chk(rd_we == 2'b11 && rd_even == mem_rdata[127:64] && rd_odd == mem_rdata[63:0],
        "R6 quad load", {rd_even, rd_odd}, mem_rdata);
    cs_expect(32'h5010, 1'b1, 1'b1, "R6 quad cs");
    chk(mem_wdata == {st_even, st_odd} && mem_wide == 1, "R6 quad write",
        mem_wdata, {st_even, st_odd});

    // R7 context loss
    do_req(OP_RSV, 32'h6000, 1'b0);
    pulse(1'b0, 32'h0, 1'b1);
    cs_expect(32'h6000, 1'b0, 1'b0, "R7 ctx loss clears");
    replay_mode = 1'b1;
    do_req(OP_RSV, 32'h6000, 1'b0);
    pulse(1'b0, 32'h0, 1'b1);
    cs_expect(32'h6000, 1'b0, 1'b1, "R7 replay keeps");
    replay_mode = 1'b0;

    // R8 own plain stores
    do_req(OP_RSV, 32'h7000, 1'b0);
    do_req(OP_ST, 32'h7040, 1'b0);
    chk(mem_we == 1 && mem_addr == 32'h7040, "R8 plain store writes",
        128'({mem_we, mem_addr}), 128'({1'b1, 32'h7040}));
    cs_expect(32'h7000, 1'b0, 1'b0, "R8 own store kills");
    do_req(OP_RSV, 32'h7000, 1'b0);
    do_req(OP_ST, 32'h7080, 1'b0);
    cs_expect(32'h7000, 1'b0, 1'b1, "R8 other granule store keeps");

    // R9 snoops
    do_req(OP_RSV, 32'h8000, 1'b0);
    pulse(1'b1, 32'h807C, 1'b0);
    cs_expect(32'h8000, 1'b0, 1'b0, "R9 snoop hit");
    do_req(OP_RSV, 32'h8000, 1'b0);
    pulse(1'b1, 32'h8080, 1'b0);
    cs_expect(32'h8000, 1'b0, 1'b1, "R9 snoop miss");

    // R10 replace then R11 clear
    do_req(OP_RSV, 32'h9000, 1'b0);
    do_req(OP_RSV, 32'hA000, 1'b0);
    cs_expect(32'hA000, 1'b0, 1'b1, "R10 new reservation");
    do_req(OP_RSV, 32'hA000, 1'b0);
    do_req(OP_CLR, 32'h0, 1'b0);
    cs_expect(32'hA000, 1'b0, 1'b0, "R11 clear request");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule